// File: doc/BRIEF.md
# System Clock Mode Switch Controller

This block selects which of five clock modes drives the master clock of a small system clock unit. Four oscillators can be requested: a high-speed internal RC, a main crystal oscillator, a PLL fed by the main oscillator, and a sub clock oscillator. A fifth source, the low-speed internal RC, is always running and always usable. Software writes a 3-bit mode-select field, per-source enable bits and a 4-bit stabilization wait code per source. The block turns these into run requests for the analog oscillators. It times each source's stabilization with a counter driven by an always-on reference tick, and it raises a per-source ready flag when the wait ends.

The master clock moves to the selected mode only once every source that mode needs is ready. Until then the status output keeps showing the old mode. Software polls until the status equals its selection. The sub clock and low-speed RC modes are low-power modes. In them the block keeps the three fast sources stopped whatever the enable bits say. A fast source starts only when the mode-select field names a mode that needs it and its enable bit is also set.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, `cur_mode` is 3'b101 (low-speed RC), and `run_req` and `osc_ready` are all zero. Bit indices of `osc_en`, `run_req` and `osc_ready` are: 0 high-speed RC, 1 main oscillator, 2 PLL, 3 sub clock.
- R2: While `cur_mode` is a low-power mode (3'b100 sub clock or 3'b101 low-speed RC), `run_req[2:0]` stays 0 for any source that `mode_sel` does not need, even when its enable bit is set.
- R3: In a low-power mode, `run_req` of a fast source rises on the first clock edge after `mode_sel` names a mode that needs it, provided its enable bit is set. Mode codes: 000 high-speed RC, 001 main (needs bit 1), 010 PLL run (needs bits 1 and 2).
- R4: `osc_ready[i]` rises after the run request has been high for 2^(n+4) cycles with `ref_tick` high, where n is `wait_cfg[4i+3:4i]`. Cycles with `ref_tick` low do not count. The flag clears when the run request drops.
- R5: `cur_mode` takes the value of `mode_sel` on the edge after every source the selected mode needs is ready. Until then `cur_mode` keeps the old mode.
- R6: The PLL wait counts only while the main oscillator is ready. PLL run mode needs both flags.
- R7: One cycle after `cur_mode` changes to a low-power mode that is also selected, `run_req[2:0]` is 0.
- R8: Mode codes 011, 110 and 111 are ignored: `cur_mode` keeps its value and no fast source starts.
- R9: Outside the low-power modes, every enabled source is requested. Every source the current mode uses stays requested even when its enable bit is cleared.
- R10: `run_req[3]` follows `osc_en[3]` in every mode. Sub clock mode needs `osc_ready[3]`. Low-speed RC mode can be entered at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Always-on reference tick that advances the stabilization counters |
| mode_sel | input | 3 | Requested clock mode code |
| osc_en | input | 4 | Oscillation enable per source (0 HRC, 1 main, 2 PLL, 3 sub) |
| wait_cfg | input | 16 | 4-bit stabilization wait code per source, source i in bits 4i+3:4i |
| run_req | output | 4 | Run request to each oscillator |
| osc_ready | output | 4 | Stabilization finished flag per source |
| cur_mode | output | 3 | Mode actually driving the master clock |

## Verification
The switch is tried from low-power modes with enables set but no fast mode selected, which shows whether the gating holds. It is also tried with main-only, PLL and high-speed RC targets. Their exact ready-edge timing separates an off-by-one counter from a correct one. Running the PLL target from a cold main oscillator shows whether the PLL wait really waits for main readiness. A stretch with the reference tick held low shows whether the counters advance on clock edges or only on ticks. The tests also cover illegal mode codes, cleared enables while a source is in use, and a sub clock target with its enable off. These show whether the status keeps its old value and whether sources in use stay requested.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam int NSRC = 4;

  localparam int IDX_HRC  = 0;
  localparam int IDX_MAIN = 1;
  localparam int IDX_PLL  = 2;
  localparam int IDX_SUB  = 3;

  localparam logic [2:0] MODE_HRC  = 3'b000;
  localparam logic [2:0] MODE_MAIN = 3'b001;
  localparam logic [2:0] MODE_PLL  = 3'b010;
  localparam logic [2:0] MODE_SUB  = 3'b100;
  localparam logic [2:0] MODE_LRC  = 3'b101;

  function automatic logic mode_valid(input logic [2:0] m);
    return (m == MODE_HRC) || (m == MODE_MAIN) || (m == MODE_PLL) ||
           (m == MODE_SUB) || (m == MODE_LRC);
  endfunction

  function automatic logic mode_lowpwr(input logic [2:0] m);
    return (m == MODE_SUB) || (m == MODE_LRC);
  endfunction

  // sources a mode depends on, indexed as IDX_*
  function automatic logic [NSRC-1:0] mode_need(input logic [2:0] m);
    logic [NSRC-1:0] n;
    n = '0;
    case (m)
      MODE_HRC:  n[IDX_HRC] = 1'b1;
      MODE_MAIN: n[IDX_MAIN] = 1'b1;
      MODE_PLL:  begin n[IDX_MAIN] = 1'b1; n[IDX_PLL] = 1'b1; end
      MODE_SUB:  n[IDX_SUB] = 1'b1;
      default:   n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int WAIT_W    = 4,
  parameter int WAIT_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              ready
);

  localparam int CNT_W = (1 << WAIT_W) + WAIT_BASE;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = (CNT_W'(1) << (CNT_W'(wait_n) + CNT_W'(WAIT_BASE))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (tick && !ready) begin
      if (cnt == last) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> !ready); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= last); // R4

endmodule

// File: rtl/osc_run_gate.sv
module osc_run_gate
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      mode_sel,
  input  logic [2:0]      cur_mode,
  input  logic [NSRC-1:0] osc_en,
  output logic [NSRC-1:0] run_q
);

  logic            lowpwr;
  logic [NSRC-1:0] need_sel;
  logic [NSRC-1:0] need_cur;
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] run_d;

  always_comb begin
    lowpwr   = mode_lowpwr(cur_mode);
    need_sel = mode_need(mode_sel);
    need_cur = mode_need(cur_mode);
    // fast sources are held in low-power modes unless the selection wants them
    allow          = lowpwr ? need_sel : '1;
    allow[IDX_SUB] = 1'b1;
    run_d          = (osc_en & allow) | need_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_d;
  end

  AST_CUR_SOURCE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (($past(need_cur) & ~run_q) == '0)); // R9

endmodule

// File: rtl/clk_mode_switch.sv
module clk_mode_switch
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      mode_sel,
  input  logic [NSRC-1:0] ready,
  output logic [2:0]      cur_mode
);

  logic tgt_ok;

  always_comb begin
    tgt_ok = mode_valid(mode_sel) && ((mode_need(mode_sel) & ~ready) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                              cur_mode <= MODE_LRC;
    else if (tgt_ok && mode_sel != cur_mode) cur_mode <= mode_sel;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_valid(cur_mode)); // R8
  AST_MODE_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> cur_mode == $past(mode_sel)); // R5

endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int WAIT_W    = 4,
  parameter int WAIT_BASE = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_tick,
  input  logic [2:0]               mode_sel,
  input  logic [NSRC-1:0]          osc_en,
  input  logic [NSRC*WAIT_W-1:0]   wait_cfg,
  output logic [NSRC-1:0]          run_req,
  output logic [NSRC-1:0]          osc_ready,
  output logic [2:0]               cur_mode
);

  logic [NSRC-1:0] start_vec;

  osc_run_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .cur_mode (cur_mode),
    .osc_en   (osc_en),
    .run_q    (run_req)
  );

  // PLL counting waits for the main oscillator to be stable
  always_comb begin
    start_vec          = run_req;
    start_vec[IDX_PLL] = run_req[IDX_PLL] & osc_ready[IDX_MAIN];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_timer
    osc_stab_timer #(
      .WAIT_W    (WAIT_W),
      .WAIT_BASE (WAIT_BASE)
    ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick   (ref_tick),
      .start  (start_vec[i]),
      .wait_n (wait_cfg[i*WAIT_W +: WAIT_W]),
      .ready  (osc_ready[i])
    );
  end

  clk_mode_switch u_switch (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .ready    (osc_ready),
    .cur_mode (cur_mode)
  );

  AST_LP_HOLDS_FAST: assert property (@(posedge clk) disable iff (rst)
    $past(mode_lowpwr(cur_mode)) && ($past(mode_need(mode_sel)) & 4'b0111) == 4'b0000
    |-> run_req[2:0] == 3'b000); // R2
  AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> (mode_need(cur_mode) & ~$past(osc_ready)) == '0); // R5
  AST_PLL_AFTER_MAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_ready[IDX_PLL]) |-> $past(osc_ready[IDX_MAIN])); // R6
  AST_LP_ENTRY_STOPS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) && mode_lowpwr(cur_mode) && mode_lowpwr(mode_sel)
    |=> run_req[2:0] == 3'b000); // R7
  AST_SUB_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    $past(osc_en[IDX_SUB]) |-> run_req[IDX_SUB]); // R10

endmodule

// File: tb/test_sysclk_mode_ctrl.sv
module test_sysclk_mode_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ref_tick;
  logic [2:0]  mode_sel;
  logic [3:0]  osc_en;
  logic [15:0] wait_cfg;
  logic [3:0]  run_req;
  logic [3:0]  osc_ready;
  logic [2:0]  cur_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_mode_ctrl i_sysclk_mode_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .mode_sel  (mode_sel),
    .osc_en    (osc_en),
    .wait_cfg  (wait_cfg),
    .run_req   (run_req),
    .osc_ready (osc_ready),
    .cur_mode  (cur_mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_mode(input logic [2:0] m, input int limit, input string req);
    for (int i = 0; i < limit && cur_mode != m; i++) step(1);
    chk(req, "cur_mode reached", int'(cur_mode), int'(m));
  endtask

  task automatic t_reset;
    rst = 1'b1; ref_tick = 1'b1; mode_sel = 3'b101; osc_en = 4'b0000; wait_cfg = 16'h0000;
    step(3);
    chk("R1", "cur_mode", int'(cur_mode), 5);
    chk("R1", "run_req", int'(run_req), 0);
    chk("R1", "osc_ready", int'(osc_ready), 0);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_lowpwr_hold;
    osc_en = 4'b0111;
    step(5);
    chk("R2", "fast run_req with enables set", int'(run_req[2:0]), 0);
    chk("R2", "cur_mode", int'(cur_mode), 5);
    mode_sel = 3'b110; step(5);
    chk("R8", "run_req after code 110", int'(run_req[2:0]), 0);
    chk("R8", "cur_mode after code 110", int'(cur_mode), 5);
    mode_sel = 3'b111; step(5);
    chk("R8", "cur_mode after code 111", int'(cur_mode), 5);
  endtask

  task automatic t_main_switch;
    mode_sel = 3'b001;
    step(1);
    chk("R3", "main run", int'(run_req[1]), 1);
    chk("R3", "hrc run not needed", int'(run_req[0]), 0);
    chk("R2", "pll run not needed", int'(run_req[2]), 0);
    step(15);
    chk("R4", "main ready one tick early", int'(osc_ready[1]), 0);
    chk("R5", "mode held while waiting", int'(cur_mode), 5);
    step(1);
    chk("R4", "main ready at 16 ticks", int'(osc_ready[1]), 1);
    chk("R5", "mode before switch edge", int'(cur_mode), 5);
    step(1);
    chk("R5", "mode switched to main", int'(cur_mode), 1);
    step(1);
    chk("R9", "enabled hrc and pll run", int'(run_req[2:0]), 7);
  endtask

  task automatic t_enter_lowpwr;
    mode_sel = 3'b101;
    step(1);
    chk("R10", "low-speed RC entered at once", int'(cur_mode), 5);
    step(1);
    chk("R7", "fast run stopped", int'(run_req[2:0]), 0);
    step(1);
    chk("R4", "ready cleared after run drop", int'(osc_ready[2:0]), 0);
  endtask

  task automatic t_tick_gate;
    osc_en = 4'b0001; ref_tick = 1'b0; mode_sel = 3'b000;
    step(1);
    chk("R3", "hrc run", int'(run_req[0]), 1);
    step(30);
    chk("R4", "hrc not ready without ticks", int'(osc_ready[0]), 0);
    ref_tick = 1'b1;
    step(15);
    chk("R4", "hrc ready one tick early", int'(osc_ready[0]), 0);
    step(1);
    chk("R4", "hrc ready at 16 ticks", int'(osc_ready[0]), 1);
    step(1);
    chk("R5", "mode switched to hrc", int'(cur_mode), 0);
    mode_sel = 3'b101;
    step(3);
  endtask

  task automatic t_pll_switch;
    osc_en = 4'b0111; wait_cfg = 16'h0100; mode_sel = 3'b010;
    step(1);
    chk("R3", "main and pll run, hrc not", int'(run_req[2:0]), 6);
    step(16);
    chk("R6", "main ready, pll not", int'(osc_ready[2:1]), 1);
    chk("R6", "mode held for pll", int'(cur_mode), 5);
    step(31);
    chk("R6", "pll ready one tick early", int'(osc_ready[2]), 0);
    step(1);
    chk("R6", "pll ready at 32 ticks after main", int'(osc_ready[2]), 1);
    step(1);
    chk("R6", "mode switched to pll", int'(cur_mode), 2);
    mode_sel = 3'b011; step(5);
    chk("R8", "code 011 ignored", int'(cur_mode), 2);
    mode_sel = 3'b010; step(1);
  endtask

  task automatic t_keep_and_sub;
    osc_en = 4'b0000;
    step(2);
    chk("R9", "sources in use kept, hrc stopped", int'(run_req[2:0]), 6);
    chk("R10", "sub run follows enable", int'(run_req[3]), 0);
    mode_sel = 3'b100;
    step(40);
    chk("R10", "sub mode blocked without sub ready", int'(cur_mode), 2);
    osc_en = 4'b1000;
    step(1);
    chk("R10", "sub run after enable", int'(run_req[3]), 1);
    wait_mode(3'b100, 40, "R10");
    step(1);
    chk("R7", "fast run stopped in sub mode", int'(run_req[2:0]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lowpwr_hold();
    t_main_switch();
    t_enter_lowpwr();
    t_tick_gate();
    t_pll_switch();
    t_keep_and_sub();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule